// File: doc/BRIEF.md
# Attribute Index/Data Toggle Port

This block is the host-side register port of a display attribute stage. One bus address takes every write. An internal toggle decides what each write means. In the index phase the byte picks a target register and sets a palette-source bit. In the data phase the byte is stored into the register that the index picked, and the toggle goes back to the index phase. A second bus address reads the register that the index picks, and these reads never move the toggle. A read strobe at a third address stands for the status-register read that software uses to put the toggle back in a known state. That read forces the index phase.

The port holds sixteen 6-bit palette entries and five mode registers. It drives the current index and the palette-source bit as outputs. When the source bit is 0, the host owns the palette and may load it. While the bit is 0, the combinational pixel lookup port reads as zero. When the bit is 1, the display owns the palette. Host writes to palette entries are then dropped, and the pixel port returns the entry that the attribute input selects.

Top module: `attr_port`

## Requirements
- R1: After reset the toggle is in the index phase. The index, the source bit, every register and the read data are all zero.
- R2: A write to address 0 in the index phase does three things on the next edge: it loads bits 4:0 into the index, it loads bit 5 into the source bit, and it enters the data phase.
- R3: A write to address 0 in the data phase stores the byte into the indexed register and returns the toggle to the index phase. The index and the source bit keep their values.
- R4: A read strobe at address 1 puts the indexed register, zero-extended, on the read data at the next edge. It leaves the toggle, the index and the source bit unchanged.
- R5: A read strobe at address 2 forces the index phase and returns zero on the read data.
- R6: Indexes 0 to 15 are palette entries of 6 bits. Bits 7:6 of the written byte are dropped, and those bits read back as zero.
- R7: Index 16 is an 8-bit mode register and index 17 is an 8-bit border colour register. Index 18 is the plane enable register, index 19 the pixel pan register and index 20 the colour select register; each of these three is 4 bits wide and reads back with zeros above.
- R8: Data writes to indexes 21 to 31 change no register, but they still return the toggle to the index phase. Reads of those indexes return zero.
- R9: While the source bit is 1, data writes to palette indexes are dropped. The toggle still returns to the index phase.
- R10: The pixel port output is palette entry pixAttr while the source bit is 1, and zero while it is 0. The output is combinational.
- R11: A write strobe at addresses 1 to 3 and a read strobe at addresses 0 or 3 change no state. A read strobe at those addresses returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 2 | Port address: 0 index/data write, 1 data read, 2 status read |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, registered on rdEn |
| curIdx | output | 5 | Current register index |
| palSrc | output | 1 | Palette source bit: 0 host loads, 1 display uses |
| pixAttr | input | 4 | Attribute number for the pixel lookup |
| pixColor | output | 6 | Palette entry for pixAttr, or zero |

## Verification
Directed runs check the toggle in three patterns. Index then data shows that the toggle flips back. Index, several data reads, then data shows that reads do not advance it. Index, status read, then a write shows that the write is taken as a new index. Each register is written with all ones and with mixed bytes, so that field widths and ignored indexes can be told apart. The palette is loaded and then swept with the source bit at both values, which separates the write block from the lookup gating. A long run of pseudo-random strobes at all four addresses, checked against a behavioural model on every clock, then mixes these orderings in ways the directed runs do not reach.

// File: rtl/attr_port_pkg.sv
package attr_port_pkg;

  // Strobes passed from the port control to the register datapath
  typedef struct packed {
    logic idxLoad;   // write taken as an index
    logic dataLoad;  // write taken as data
    logic dataRead;  // read of the indexed register
    logic anyRead;   // any read strobe (updates the read register)
    logic phaseClr;  // status read: force the index phase
  } portStrobe_t;

endpackage

// File: rtl/attr_port_ctrl.sv
module attr_port_ctrl
  import attr_port_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int IDX_W     = 5,
  parameter int WR_ADDR   = 0,
  parameter int RD_ADDR   = 1,
  parameter int STAT_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [IDX_W:0]    idxByte,
  output portStrobe_t       strb,
  output logic [IDX_W-1:0]  curIdx,
  output logic              palSrc,
  output logic              dataPhase
);

  logic wrHit, rdHit, statHit;

  always_comb begin
    wrHit   = (busAddr == ADDR_W'(WR_ADDR));
    rdHit   = (busAddr == ADDR_W'(RD_ADDR));
    statHit = (busAddr == ADDR_W'(STAT_ADDR));
    strb.idxLoad  = wrEn && wrHit && !dataPhase;
    strb.dataLoad = wrEn && wrHit && dataPhase;
    strb.dataRead = rdEn && rdHit;
    strb.anyRead  = rdEn;
    strb.phaseClr = rdEn && statHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataPhase <= 1'b0;
      curIdx    <= '0;
      palSrc    <= 1'b0;
    end else if (strb.idxLoad) begin
      curIdx    <= idxByte[IDX_W-1:0];
      palSrc    <= idxByte[IDX_W];
      dataPhase <= 1'b1;
    end else if (strb.dataLoad || strb.phaseClr) begin
      dataPhase <= 1'b0;
    end
  end

endmodule

// File: rtl/attr_port_regs.sv
module attr_port_regs
  import attr_port_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 5,
  parameter int PAL_N   = 16,
  parameter int PAL_W   = 6,
  parameter int PLANE_W = 4,
  parameter int PAN_W   = 4,
  parameter int CSEL_W  = 4,
  localparam int ATTR_W = $clog2(PAL_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  portStrobe_t       strb,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic              palSrc,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [ATTR_W-1:0] pixAttr,
  output logic [PAL_W-1:0]  pixColor
);

  localparam int MODE_IDX  = PAL_N;
  localparam int BORD_IDX  = PAL_N + 1;
  localparam int PLANE_IDX = PAL_N + 2;
  localparam int PAN_IDX   = PAL_N + 3;
  localparam int CSEL_IDX  = PAL_N + 4;

  logic [PAL_W-1:0]   palReg [PAL_N];
  logic [DATA_W-1:0]  modeReg, bordReg;
  logic [PLANE_W-1:0] planeReg;
  logic [PAN_W-1:0]   panReg;
  logic [CSEL_W-1:0]  cselReg;
  logic [DATA_W-1:0]  selVal;
  logic               palWrOk;

  assign palWrOk = strb.dataLoad && !palSrc;

  // One register per palette entry, each with its own write decode
  for (genvar k = 0; k < PAL_N; k++) begin : g_pal
    always_ff @(posedge clk) begin
      if (rst) begin
        palReg[k] <= '0;
      end else if (palWrOk && (int'(curIdx) == k)) begin
        palReg[k] <= wrData[PAL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg  <= '0;
      bordReg  <= '0;
      planeReg <= '0;
      panReg   <= '0;
      cselReg  <= '0;
    end else if (strb.dataLoad) begin
      case (int'(curIdx))
        MODE_IDX:  modeReg  <= wrData;
        BORD_IDX:  bordReg  <= wrData;
        PLANE_IDX: planeReg <= wrData[PLANE_W-1:0];
        PAN_IDX:   panReg   <= wrData[PAN_W-1:0];
        CSEL_IDX:  cselReg  <= wrData[CSEL_W-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    selVal = '0;
    if (int'(curIdx) < PAL_N) begin
      selVal[PAL_W-1:0] = palReg[curIdx[ATTR_W-1:0]];
    end else begin
      case (int'(curIdx))
        MODE_IDX:  selVal = modeReg;
        BORD_IDX:  selVal = bordReg;
        PLANE_IDX: selVal[PLANE_W-1:0] = planeReg;
        PAN_IDX:   selVal[PAN_W-1:0]   = panReg;
        CSEL_IDX:  selVal[CSEL_W-1:0]  = cselReg;
        default:   selVal = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.anyRead) begin
      rdData <= strb.dataRead ? selVal : '0;
    end
  end

  assign pixColor = palSrc ? palReg[pixAttr] : '0;

endmodule

// File: rtl/attr_port.sv
module attr_port
  import attr_port_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 5,
  parameter int PAL_N     = 16,
  parameter int PAL_W     = 6,
  parameter int PLANE_W   = 4,
  parameter int PAN_W     = 4,
  parameter int CSEL_W    = 4,
  parameter int WR_ADDR   = 0,
  parameter int RD_ADDR   = 1,
  parameter int STAT_ADDR = 2,
  localparam int ATTR_W   = $clog2(PAL_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  curIdx,
  output logic              palSrc,
  input  logic [ATTR_W-1:0] pixAttr,
  output logic [PAL_W-1:0]  pixColor
);

  portStrobe_t strb;
  logic        dataPhase;

  attr_port_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn),
    .idxByte(wrData[IDX_W:0]), .strb(strb), .curIdx(curIdx),
    .palSrc(palSrc), .dataPhase(dataPhase)
  );

  attr_port_regs #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .PAL_N(PAL_N), .PAL_W(PAL_W),
    .PLANE_W(PLANE_W), .PAN_W(PAN_W), .CSEL_W(CSEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .strb(strb), .curIdx(curIdx), .palSrc(palSrc),
    .wrData(wrData), .rdData(rdData), .pixAttr(pixAttr), .pixColor(pixColor)
  );

endmodule

// File: rtl/attr_port_chk.sv
module attr_port_chk #(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 5,
  parameter int PAL_W     = 6,
  parameter int WR_ADDR   = 0,
  parameter int RD_ADDR   = 1,
  parameter int STAT_ADDR = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [IDX_W-1:0]  curIdx,
  input logic              palSrc,
  input logic [PAL_W-1:0]  pixColor,
  input logic              dataPhase
);

  // R2
  index_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && busAddr == ADDR_W'(WR_ADDR) && !dataPhase) |=>
      (dataPhase && curIdx == $past(wrData[IDX_W-1:0]) && palSrc == $past(wrData[IDX_W])));

  // R3
  data_return_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && busAddr == ADDR_W'(WR_ADDR) && dataPhase) |=>
      (!dataPhase && $stable(curIdx) && $stable(palSrc)));

  // R4
  read_keeps_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && busAddr == ADDR_W'(RD_ADDR)) |=> ($stable(dataPhase) && $stable(curIdx)));

  // R5
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && busAddr == ADDR_W'(STAT_ADDR)) |=> (!dataPhase && rdData == '0));

  // R10
  pix_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (!palSrc) |-> (pixColor == '0));

  // R11
  idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !rdEn && busAddr != ADDR_W'(WR_ADDR)) |=>
      ($stable(dataPhase) && $stable(curIdx) && $stable(palSrc) && $stable(rdData)));

endmodule

bind attr_port attr_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .PAL_W(PAL_W),
  .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .curIdx(curIdx), .palSrc(palSrc),
  .pixColor(pixColor), .dataPhase(dataPhase)
);

// File: tb/tb_attr_port.sv
`timescale 1ns/1ps
module tb_attr_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] busAddr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [4:0] curIdx;
  logic       palSrc;
  logic [3:0] pixAttr = '0;
  logic [5:0] pixColor;

  always #2 clk = ~clk;  // 250 MHz

  attr_port dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .curIdx(curIdx), .palSrc(palSrc),
    .pixAttr(pixAttr), .pixColor(pixColor)
  );

  // Behavioural reference model
  int  mPal [16];
  int  mMode, mBord, mPlane, mPan, mCsel;
  int  mIdx, mRd;
  bit  mSrc, mPhase;

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R1";
  bit    done    = 0;

  function automatic int mVal(int i);
    if (i < 16) return mPal[i];
    case (i)
      16: return mMode;
      17: return mBord;
      18: return mPlane;
      19: return mPan;
      20: return mCsel;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mPal[i]) mPal[i] = 0;
      mMode = 0; mBord = 0; mPlane = 0; mPan = 0; mCsel = 0;
      mIdx = 0; mRd = 0; mSrc = 0; mPhase = 0;
    end else begin
      if (wrEn && busAddr == 2'd0) begin
        if (!mPhase) begin
          mIdx = wrData & 31;
          mSrc = wrData[5];
          mPhase = 1;
        end else begin
          if (mIdx < 16) begin
            if (!mSrc) mPal[mIdx] = wrData & 63;
          end else if (mIdx == 16) mMode = wrData;
          else if (mIdx == 17) mBord = wrData;
          else if (mIdx == 18) mPlane = wrData & 15;
          else if (mIdx == 19) mPan = wrData & 15;
          else if (mIdx == 20) mCsel = wrData & 15;
          mPhase = 0;
        end
      end
      if (rdEn) begin
        mRd = (busAddr == 2'd1) ? mVal(mIdx) : 0;
        if (busAddr == 2'd2) mPhase = 0;
      end
    end
  end

  task automatic compareAll();
    int expPix;
    expPix = mSrc ? mPal[pixAttr] : 0;
    nChecks++;
    if (rdData !== 8'(mRd) || curIdx !== 5'(mIdx) || palSrc !== mSrc ||
        pixColor !== 6'(expPix)) begin
      nFails++;
      $display("FAIL %s: rd=%h idx=%0d src=%b pix=%h, expected rd=%h idx=%0d src=%b pix=%h",
               curReq, rdData, curIdx, palSrc, pixColor, 8'(mRd), mIdx, mSrc, 6'(expPix));
    end
  endtask

  task automatic busOp(input logic [1:0] a, input logic we, input logic re,
                       input logic [7:0] d, input logic [3:0] px);
    @(negedge clk);
    compareAll();
    busAddr = a; wrEn = we; rdEn = re; wrData = d; pixAttr = px;
  endtask

  task automatic wr(input logic [7:0] d);  busOp(2'd0, 1'b1, 1'b0, d, pixAttr); endtask
  task automatic rd();                     busOp(2'd1, 1'b0, 1'b1, 8'h00, pixAttr); endtask
  task automatic stat();                   busOp(2'd2, 1'b0, 1'b1, 8'h00, pixAttr); endtask
  task automatic idle();                   busOp(2'd0, 1'b0, 1'b0, 8'h00, pixAttr); endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    rst = 1'b1;
    repeat (3) idle();
    @(negedge clk); rst = 1'b0;
    idle(); idle();

    // R2: index write
    curReq = "R2";
    wr(8'h05); idle();
    // R3: data write returns to index phase
    curReq = "R3";
    wr(8'h2C); idle(); rd(); idle();
    wr(8'h10); wr(8'hA5); rd(); idle();

    // R4: reads do not move the toggle
    curReq = "R4";
    wr(8'h05); rd(); rd(); idle(); wr(8'h12); rd(); idle();

    // R5: status read forces index phase
    curReq = "R5";
    wr(8'h13); stat(); idle(); wr(8'h07); wr(8'h09); rd(); idle();

    // R6: palette width
    curReq = "R6";
    for (int k = 0; k < 16; k++) begin
      wr(8'(k)); wr(8'hC0 | 8'(k * 3)); rd();
    end
    idle();

    // R7: mode registers and their widths
    curReq = "R7";
    for (int k = 16; k <= 20; k++) begin
      wr(8'(k)); wr(8'hFF); rd(); idle();
      wr(8'(k)); wr(8'h5A); rd(); idle();
    end

    // R8: unimplemented indexes
    curReq = "R8";
    for (int k = 21; k < 32; k++) begin
      wr(8'(k)); wr(8'h77); rd(); idle();
    end
    wr(8'h02); rd(); idle();

    // R9: palette locked while display owns it
    curReq = "R9";
    wr(8'h23); wr(8'h2A); rd(); idle(); wr(8'h03); rd(); idle();

    // R10: pixel lookup with both source settings
    curReq = "R10";
    wr(8'h20); idle();
    for (int k = 0; k < 16; k++) busOp(2'd3, 1'b0, 1'b0, 8'h00, 4'(k));
    wr(8'h00); idle();
    for (int k = 0; k < 16; k++) busOp(2'd3, 1'b0, 1'b0, 8'h00, 4'(15 - k));
    idle();

    // R11: strobes at unused or wrong addresses
    curReq = "R11";
    wr(8'h11); busOp(2'd1, 1'b1, 1'b0, 8'h33, 4'd0);
    busOp(2'd2, 1'b1, 1'b0, 8'h44, 4'd0); busOp(2'd3, 1'b1, 1'b0, 8'h55, 4'd0);
    busOp(2'd0, 1'b0, 1'b1, 8'h00, 4'd0); busOp(2'd3, 1'b0, 1'b1, 8'h00, 4'd0);
    wr(8'h66); rd(); idle();

    // Mixed pseudo-random traffic
    curReq = "R2";
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] a;
      logic       w;
      a = 2'($urandom_range(0, 3));
      w = 1'($urandom_range(0, 1));
      if (n % 4 == 0) curReq = "R3";
      else if (n % 4 == 1) curReq = "R4";
      else if (n % 4 == 2) curReq = "R9";
      else curReq = "R10";
      busOp(a, w, !w && ($urandom_range(0, 2) != 0), 8'($urandom_range(0, 255)),
            4'($urandom_range(0, 15)));
    end
    idle(); idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule